// File: doc/BRIEF.md
# E-paper panel timing generator

This block produces the line and frame timing for an electrophoretic display panel. Software programs four horizontal segment lengths (sync, leading porch, data, trailing porch) in source clocks and four vertical segment lengths in lines. From these the block derives horizontal and vertical sync, a per-line active-region flag, the source-driver enable and the gate-driver clock pulse. All timing is counted on the source clock that drives `clk`.

A run starts on a rising edge of the start input and sweeps a programmed number of whole frames. It then returns to idle with every timing output low. Configuration inputs feed a shadow copy, and only that copy steers the counters. A load strobe moves the inputs into the copy at once when the block is idle. During a run the move is held until the current frame ends. Four sticky event flags report frame ends, frame starts, a programmable line hit and the end of the whole run. Each flag has a mask bit toward the interrupt line and a write-one-to-clear bit.

Top module: `epd_timing_gen`

## Requirements
- R1: A line lasts h_sync+h_begin+h_data+h_end clocks, and hsync is high for the first h_sync+2 clocks of every line (h_sync+2 must be less than the line length).
- R2: A frame lasts v_sync+v_begin+v_data+v_end lines, and vsync is high for the first v_sync whole lines of every frame.
- R3: line_active is high for the whole of lines v_sync+v_begin through v_sync+v_begin+v_data-1 of each frame and low on every other line.
- R4: src_en is high for exactly h_data clocks on each active line and never on other lines. Its compare point is line position h_sync+h_begin-1, so its first high clock comes h_sync+h_begin clocks after the hsync rising edge (h_sync+h_begin must be at least 1).
- R5: gate_clk rises gate_ofs+h_sync clocks after the hsync rising edge. It stays high for gate_on clocks, and only on active lines.
- R6: A 0-to-1 change of run_start while idle launches a run of frames_m1+1 frames. A start held high does not launch a second run: it has to return to 0 first.
- R7: After reset and after each run, the counters hold at zero and hsync, vsync, line_active, src_en and gate_clk stay low until the next launch.
- R8: The timing outputs follow the configuration inputs only after a cfg_load pulse. A load while idle takes effect on the next clock. A load during a run takes effect from the next frame boundary.
- R9: int_status holds sticky flags: bit 0 at the end of every frame, bit 1 once when the last frame's final line completes, bit 2 at the start of every frame, and bit 3 when the line counter equals line_flag_at at the start of a line.
- R10: A 1 on int_clr bit n clears int_status bit n on the next clock unless the same event fires in that cycle. Other bits are left as they are.
- R11: irq is the OR of the int_status bits whose int_mask bit is 0; a mask bit of 1 blocks that flag.
- R12: gate_scan_dir and src_scan_dir present the loaded gate and source scan direction bits, with the same load rule as the timing fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Global load strobe for the shadow configuration |
| run_start | input | 1 | Run launch level, acted on at its rising edge |
| h_sync_len | input | 12 | Horizontal sync segment, clocks |
| h_begin_len | input | 12 | Horizontal leading porch, clocks |
| h_data_len | input | 12 | Horizontal data segment, clocks |
| h_end_len | input | 12 | Horizontal trailing porch, clocks |
| v_sync_len | input | 11 | Vertical sync segment, lines |
| v_begin_len | input | 11 | Vertical leading porch, lines |
| v_data_len | input | 11 | Vertical data segment, lines |
| v_end_len | input | 11 | Vertical trailing porch, lines |
| gate_rise_ofs | input | 12 | Gate clock rise offset beyond the hsync segment |
| gate_on_len | input | 12 | Gate clock high length, clocks |
| frames_m1 | input | 8 | Number of frames per run minus one |
| line_flag_at | input | 11 | Line number that raises the line-hit flag |
| gate_scan_up | input | 1 | Gate scan direction, 1 = bottom to top |
| src_scan_rtl | input | 1 | Source scan direction, 1 = right to left |
| int_mask | input | 4 | Per-flag interrupt block, 1 = blocked |
| int_clr | input | 4 | Per-flag write-one-to-clear |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| line_active | output | 1 | Current line is in the vertical data region |
| src_en | output | 1 | Source-driver enable |
| gate_clk | output | 1 | Gate-driver clock pulse |
| gate_scan_dir | output | 1 | Loaded gate scan direction |
| src_scan_dir | output | 1 | Loaded source scan direction |
| int_status | output | 4 | Sticky event flags |
| irq | output | 1 | Interrupt request |

## Verification
Some rules are checked by assertions on every cycle. The line counter stays below the line length. src_en and gate_clk appear only inside active lines, and the timing outputs are silent one cycle after the block is idle. A run ends only on a frame boundary, and the run-end flag rises exactly when the run drops. The shadow copy never changes without a pending or fresh load, a cleared flag stays cleared, and a fully masked flag set raises no interrupt. Other behaviour can only be shown by the bench's scenarios. That covers the absolute lengths and offsets of each pulse against the programmed segments, and the number of frames in a run. It also covers the deferral of a mid-run load to the next frame and the refusal to relaunch on a held start.

// File: rtl/epd_tg_pkg.sv
package epd_tg_pkg;
  localparam int unsigned HW  = 12;  // horizontal count width
  localparam int unsigned VW  = 11;  // vertical count width
  localparam int unsigned FW  = 8;   // frame count width
  localparam int unsigned NEV = 4;   // number of event flags

  // flag bit positions, fixed because software decodes them
  localparam int unsigned EV_FRAME_END   = 0;
  localparam int unsigned EV_DISP_END    = 1;
  localparam int unsigned EV_FRAME_BEGIN = 2;
  localparam int unsigned EV_LINE_HIT    = 3;

  typedef struct packed {
    logic [HW-1:0] h_sync;
    logic [HW-1:0] h_begin;
    logic [HW-1:0] h_data;
    logic [HW-1:0] h_end;
    logic [VW-1:0] v_sync;
    logic [VW-1:0] v_begin;
    logic [VW-1:0] v_data;
    logic [VW-1:0] v_end;
    logic [HW-1:0] gate_ofs;
    logic [HW-1:0] gate_on;
    logic [FW-1:0] frames_m1;
    logic [VW-1:0] line_flag;
    logic          gate_up;
    logic          src_rtl;
  } tg_cfg_t;
endpackage

// File: rtl/epd_tg_shadow.sv
module epd_tg_shadow
  import epd_tg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  logic    running,
  input  logic    frame_last,
  input  tg_cfg_t cfg_wr,
  output tg_cfg_t cfg_act
);
  logic pend;
  logic apply;

  // copy only while idle or on the last clock of a frame
  assign apply = (load | pend) & (~running | frame_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_act <= '0;
      pend    <= 1'b0;
    end else begin
      if (apply) cfg_act <= cfg_wr;
      if (apply)     pend <= 1'b0;
      else if (load) pend <= 1'b1;
    end
  end

  // R8
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load) && !$past(pend)) |-> $stable(cfg_act));
endmodule

// File: rtl/epd_tg_seg_ctr.sv
module epd_tg_seg_ctr #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         step,
  input  logic [W-1:0] total,
  output logic [W-1:0] cnt,
  output logic         last
);
  assign last = run && step && (cnt == total - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (step)  cnt <= last ? '0 : cnt + W'(1);
  end

  // R1
  seg_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && total != '0) |-> (cnt < total));
endmodule

// File: rtl/epd_tg_seq.sv
module epd_tg_seq
  import epd_tg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          frame_last,
  input  logic [FW-1:0] frames_m1,
  output logic          running,
  output logic          launch,
  output logic          run_last
);
  logic          start_q;
  logic [FW-1:0] fidx;

  assign launch   = start & ~start_q & ~running;
  assign run_last = frame_last & (fidx >= frames_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      running <= 1'b0;
      fidx    <= '0;
    end else begin
      start_q <= start;
      if (launch) begin
        running <= 1'b1;
        fidx    <= '0;
      end else if (run_last) begin
        running <= 1'b0;
        fidx    <= '0;
      end else if (frame_last) begin
        fidx    <= fidx + FW'(1);
      end
    end
  end

  // R6
  run_ends_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> $past(frame_last));
endmodule

// File: rtl/epd_tg_irq.sv
module epd_tg_irq
  import epd_tg_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] ev,
  input  logic [NEV-1:0] clr,
  input  logic [NEV-1:0] mask,
  output logic [NEV-1:0] st,
  output logic           irq
);
  // a new event outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= '0;
    else        st <= (st & ~clr) | ev;
  end

  assign irq = |(st & ~mask);

  for (genvar b = 0; b < NEV; b++) begin : g_flag
    // R10
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(clr[b]) && !$past(ev[b])) |-> !st[b]);
  end

  // R11
  full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> !irq);
endmodule

// File: rtl/epd_timing_gen.sv
module epd_timing_gen
  import epd_tg_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_load,
  input  logic           run_start,
  input  logic [HW-1:0]  h_sync_len,
  input  logic [HW-1:0]  h_begin_len,
  input  logic [HW-1:0]  h_data_len,
  input  logic [HW-1:0]  h_end_len,
  input  logic [VW-1:0]  v_sync_len,
  input  logic [VW-1:0]  v_begin_len,
  input  logic [VW-1:0]  v_data_len,
  input  logic [VW-1:0]  v_end_len,
  input  logic [HW-1:0]  gate_rise_ofs,
  input  logic [HW-1:0]  gate_on_len,
  input  logic [FW-1:0]  frames_m1,
  input  logic [VW-1:0]  line_flag_at,
  input  logic           gate_scan_up,
  input  logic           src_scan_rtl,
  input  logic [NEV-1:0] int_mask,
  input  logic [NEV-1:0] int_clr,
  output logic           hsync,
  output logic           vsync,
  output logic           line_active,
  output logic           src_en,
  output logic           gate_clk,
  output logic           gate_scan_dir,
  output logic           src_scan_dir,
  output logic [NEV-1:0] int_status,
  output logic           irq
);
  tg_cfg_t        cfg_wr, cfg;
  logic           running, launch, run_last;
  logic           line_last, frame_last;
  logic [HW-1:0]  hcnt;
  logic [VW-1:0]  vcnt;
  logic [NEV-1:0] ev;

  // derived compare points
  logic [HW-1:0] h_total, hs_end, hact_st, hact_end, gd_st, gd_end;
  logic [VW-1:0] v_total, vact_st, vact_end;

  always_comb begin
    cfg_wr.h_sync    = h_sync_len;
    cfg_wr.h_begin   = h_begin_len;
    cfg_wr.h_data    = h_data_len;
    cfg_wr.h_end     = h_end_len;
    cfg_wr.v_sync    = v_sync_len;
    cfg_wr.v_begin   = v_begin_len;
    cfg_wr.v_data    = v_data_len;
    cfg_wr.v_end     = v_end_len;
    cfg_wr.gate_ofs  = gate_rise_ofs;
    cfg_wr.gate_on   = gate_on_len;
    cfg_wr.frames_m1 = frames_m1;
    cfg_wr.line_flag = line_flag_at;
    cfg_wr.gate_up   = gate_scan_up;
    cfg_wr.src_rtl   = src_scan_rtl;
  end

  epd_tg_shadow u_shadow (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (cfg_load),
    .running    (running),
    .frame_last (frame_last),
    .cfg_wr     (cfg_wr),
    .cfg_act    (cfg)
  );

  always_comb begin
    h_total  = cfg.h_sync + cfg.h_begin + cfg.h_data + cfg.h_end;
    hs_end   = cfg.h_sync + HW'(2);
    hact_st  = cfg.h_sync + cfg.h_begin - HW'(1);
    hact_end = cfg.h_sync + cfg.h_begin + cfg.h_data;
    gd_st    = cfg.h_sync + cfg.gate_ofs;
    gd_end   = gd_st + cfg.gate_on;
    v_total  = cfg.v_sync + cfg.v_begin + cfg.v_data + cfg.v_end;
    vact_st  = cfg.v_sync + cfg.v_begin;
    vact_end = vact_st + cfg.v_data;
  end

  epd_tg_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (run_start),
    .frame_last (frame_last),
    .frames_m1  (cfg.frames_m1),
    .running    (running),
    .launch     (launch),
    .run_last   (run_last)
  );

  epd_tg_seg_ctr #(.W(HW)) u_hctr (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (running),
    .step  (1'b1),
    .total (h_total),
    .cnt   (hcnt),
    .last  (line_last)
  );

  epd_tg_seg_ctr #(.W(VW)) u_vctr (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (running),
    .step  (line_last),
    .total (v_total),
    .cnt   (vcnt),
    .last  (frame_last)
  );

  logic line_zero, in_vact;
  assign line_zero = running && (hcnt == '0);
  assign in_vact   = (vcnt >= vact_st) && (vcnt < vact_end);

  always_comb begin
    ev                 = '0;
    ev[EV_FRAME_END]   = frame_last;
    ev[EV_DISP_END]    = run_last;
    ev[EV_FRAME_BEGIN] = line_zero && (vcnt == '0);
    ev[EV_LINE_HIT]    = line_zero && (vcnt == cfg.line_flag);
  end

  epd_tg_irq u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .ev    (ev),
    .clr   (int_clr),
    .mask  (int_mask),
    .st    (int_status),
    .irq   (irq)
  );

  // registered timing outputs, one clock behind the counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsync       <= 1'b0;
      vsync       <= 1'b0;
      line_active <= 1'b0;
      src_en      <= 1'b0;
      gate_clk    <= 1'b0;
    end else begin
      hsync       <= running && (hcnt < hs_end);
      vsync       <= running && (vcnt < cfg.v_sync);
      line_active <= running && in_vact;
      src_en      <= running && in_vact && (hcnt > hact_st) && (hcnt < hact_end);
      gate_clk    <= running && in_vact && (hcnt >= gd_st) && (hcnt < gd_end);
    end
  end

  assign gate_scan_dir = cfg.gate_up;
  assign src_scan_dir  = cfg.src_rtl;

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(running) |-> !(hsync || vsync || line_active || src_en || gate_clk));
  // R4
  src_in_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_en |-> line_active);
  // R5
  gate_in_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_clk |-> line_active);
  // R9
  disp_end_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_status[EV_DISP_END]) |-> $fell(running));
endmodule

// File: tb/epd_timing_gen_test.sv
module epd_timing_gen_test;
  import epd_tg_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic cfg_load = 0, run_start = 0;
  logic [HW-1:0] h_sync_len = 0, h_begin_len = 0, h_data_len = 0, h_end_len = 0;
  logic [VW-1:0] v_sync_len = 0, v_begin_len = 0, v_data_len = 0, v_end_len = 0;
  logic [HW-1:0] gate_rise_ofs = 0, gate_on_len = 0;
  logic [FW-1:0] frames_m1 = 0;
  logic [VW-1:0] line_flag_at = 0;
  logic gate_scan_up = 0, src_scan_rtl = 0;
  logic [NEV-1:0] int_mask = 0, int_clr = 0;
  logic hsync, vsync, line_active, src_en, gate_clk, gate_scan_dir, src_scan_dir, irq;
  logic [NEV-1:0] int_status;

  epd_timing_gen uut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .run_start(run_start),
    .h_sync_len(h_sync_len), .h_begin_len(h_begin_len), .h_data_len(h_data_len),
    .h_end_len(h_end_len), .v_sync_len(v_sync_len), .v_begin_len(v_begin_len),
    .v_data_len(v_data_len), .v_end_len(v_end_len), .gate_rise_ofs(gate_rise_ofs),
    .gate_on_len(gate_on_len), .frames_m1(frames_m1), .line_flag_at(line_flag_at),
    .gate_scan_up(gate_scan_up), .src_scan_rtl(src_scan_rtl), .int_mask(int_mask),
    .int_clr(int_clr), .hsync(hsync), .vsync(vsync), .line_active(line_active),
    .src_en(src_en), .gate_clk(gate_clk), .gate_scan_dir(gate_scan_dir),
    .src_scan_dir(src_scan_dir), .int_status(int_status), .irq(irq)
  );

  // hs hb hd he | vs vb vd ve | gate_ofs gate_on frames_m1 line_flag
  localparam int VEC [4][12] = '{
    '{2, 3,  8, 2,  1, 2,  4, 1,  2, 5, 0,  3},
    '{1, 1,  1, 1,  1, 1,  1, 1,  0, 1, 2,  9},
    '{3, 4, 16, 5,  2, 3, 10, 2,  1, 6, 1, 12},
    '{2, 2,  6, 3,  1, 1,  6, 2,  0, 4, 3,  0}
  };

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  // output monitor, sampled on the falling edge
  logic mon_clr = 0;
  logic p_hs = 0, p_vs = 0, p_sd = 0, p_g = 0;
  int m_hs_hi, m_hs_rise, m_vs_hi, m_vs_rise, m_vde, m_sd, m_gate, since;
  int g_min, g_max, s_min, s_max;
  int sd_frame [8];

  always @(negedge clk) begin
    if (mon_clr) begin
      m_hs_hi = 0; m_hs_rise = 0; m_vs_hi = 0; m_vs_rise = 0;
      m_vde = 0; m_sd = 0; m_gate = 0; since = 0;
      g_min = 1000000; g_max = -1; s_min = 1000000; s_max = -1;
      for (int k = 0; k < 8; k++) sd_frame[k] = 0;
    end else begin
      if (hsync && !p_hs) begin m_hs_rise++; since = 0; end
      else since++;
      if (hsync) m_hs_hi++;
      if (vsync) m_vs_hi++;
      if (vsync && !p_vs) m_vs_rise++;
      if (line_active) m_vde++;
      if (gate_clk) m_gate++;
      if (src_en) begin
        m_sd++;
        if (m_vs_rise >= 1 && m_vs_rise <= 8) sd_frame[m_vs_rise-1]++;
      end
      if (gate_clk && !p_g) begin
        if (since < g_min) g_min = since;
        if (since > g_max) g_max = since;
      end
      if (src_en && !p_sd) begin
        if (since < s_min) s_min = since;
        if (since > s_max) s_max = since;
      end
    end
    p_hs = hsync; p_vs = vsync; p_sd = src_en; p_g = gate_clk;
  end

  task automatic set_row(input int i);
    h_sync_len    = HW'(VEC[i][0]);
    h_begin_len   = HW'(VEC[i][1]);
    h_data_len    = HW'(VEC[i][2]);
    h_end_len     = HW'(VEC[i][3]);
    v_sync_len    = VW'(VEC[i][4]);
    v_begin_len   = VW'(VEC[i][5]);
    v_data_len    = VW'(VEC[i][6]);
    v_end_len     = VW'(VEC[i][7]);
    gate_rise_ofs = HW'(VEC[i][8]);
    gate_on_len   = HW'(VEC[i][9]);
    frames_m1     = FW'(VEC[i][10]);
    line_flag_at  = VW'(VEC[i][11]);
  endtask

  task automatic load_pulse();
    cfg_load = 1; step(); cfg_load = 0;
  endtask

  task automatic prep();
    int_clr = '1; step(); int_clr = '0;
    mon_clr = 1; step(); mon_clr = 0;
  endtask

  task automatic start_pulse();
    run_start = 1; step(); run_start = 0;
  endtask

  task automatic wait_done();
    bit seen = 0;
    for (int k = 0; k < 60000; k++) begin
      if (int_status[EV_DISP_END]) begin seen = 1; break; end
      step();
    end
    chk("R6 run completes", int'(seen), 1);
    step(); step();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R6 watchdog expired: got 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    mon_clr = 1;
    repeat (3) step();
    // R7 reset state
    chk("R7 reset outputs", int'({hsync, vsync, line_active, src_en, gate_clk}), 0);
    chk("R9 reset status", int'(int_status), 0);
    chk("R11 reset irq", int'(irq), 0);
    rst_n = 1;
    step();
    mon_clr = 0;
    repeat (20) step();
    chk("R7 idle after reset, no hsync", m_hs_rise + m_vs_rise, 0);

    // R12 direction bits only move on load
    gate_scan_up = 1; src_scan_rtl = 1; step(); step();
    chk("R12 gate dir before load", int'(gate_scan_dir), 0);
    chk("R12 src dir before load", int'(src_scan_dir), 0);
    load_pulse(); step();
    chk("R12 gate dir after load", int'(gate_scan_dir), 1);
    chk("R12 src dir after load", int'(src_scan_dir), 1);

    // vector table
    for (int i = 0; i < 4; i++) begin
      int hs, hb, hd, he, vs, vb, vd, ve, gs, gon, nf, lf, ht, vt;
      hs = VEC[i][0]; hb = VEC[i][1]; hd = VEC[i][2]; he = VEC[i][3];
      vs = VEC[i][4]; vb = VEC[i][5]; vd = VEC[i][6]; ve = VEC[i][7];
      gs = VEC[i][8]; gon = VEC[i][9]; nf = VEC[i][10] + 1; lf = VEC[i][11];
      ht = hs + hb + hd + he; vt = vs + vb + vd + ve;
      set_row(i); load_pulse();
      prep(); start_pulse(); wait_done();
      chk("R1 lines per run", m_hs_rise, vt * nf);
      chk("R1 hsync high clocks", m_hs_hi, (hs + 2) * vt * nf);
      chk("R2 frames per run", m_vs_rise, nf);
      chk("R2 vsync high clocks", m_vs_hi, vs * ht * nf);
      chk("R3 active-line clocks", m_vde, vd * ht * nf);
      chk("R4 src_en clocks", m_sd, hd * vd * nf);
      chk("R4 src_en earliest offset", s_min, hs + hb);
      chk("R4 src_en latest offset", s_max, hs + hb);
      chk("R5 gate_clk clocks", m_gate, gon * vd * nf);
      chk("R5 gate rise earliest offset", g_min, hs + gs);
      chk("R5 gate rise latest offset", g_max, hs + gs);
      chk("R9 status after run", int'(int_status), (lf < vt) ? 15 : 7);
    end

    // R8 input change without load is ignored
    set_row(0); load_pulse();
    h_data_len = HW'(5);
    prep(); start_pulse(); wait_done();
    chk("R8 unloaded change ignored", m_sd, 8 * 4);
    mon_clr = 1; step(); mon_clr = 0;
    repeat (30) step();
    chk("R7 idle after run", m_hs_rise + m_vs_hi + m_sd + m_gate + m_vde, 0);

    // R8 load during a run is deferred to the frame boundary
    set_row(0); frames_m1 = FW'(1); load_pulse();
    prep(); start_pulse();
    repeat (20) step();
    h_data_len = HW'(5); load_pulse();
    wait_done();
    chk("R8 frame 0 keeps old data length", sd_frame[0], 8 * 4);
    chk("R8 frame 1 uses new data length", sd_frame[1], 5 * 4);

    // R6 a held start does not relaunch
    set_row(1); load_pulse();
    prep(); run_start = 1; step(); wait_done();
    mon_clr = 1; step(); mon_clr = 0;
    repeat (40) step();
    chk("R6 held start no relaunch", m_hs_rise, 0);
    run_start = 0; step();
    prep(); start_pulse(); wait_done();
    chk("R6 relaunch after release", m_vs_rise, 3);

    // R11 / R10 masking and clearing (status is 4'b0111 here)
    int_mask = 4'hF; step();
    chk("R11 all masked", int'(irq), 0);
    int_mask = 4'b1101; step();
    chk("R11 display-end unmasked", int'(irq), 1);
    int_clr = 4'b0010; step(); int_clr = 4'b0000; step();
    chk("R10 display-end cleared", int'(int_status[EV_DISP_END]), 0);
    chk("R10 frame-end untouched", int'(int_status[EV_FRAME_END]), 1);
    chk("R11 irq drops after clear", int'(irq), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule